// File: doc/BRIEF.md
# Dual-Channel Serial Gain-Control Slave

This block is the digital control side of a two-channel programmable gain stage. Each channel has its own four-wire serial port: a serial clock, an active-low frame strobe, a data input and a data output. It holds a 6-bit gain code per channel. A host sends 8-bit frames. The first bit chooses between storing a new code and reading back the held one. The second bit is thrown away. The last six bits carry the code, least significant bit first.

All serial pins are sampled by the core clock through synchronizers, and all decisions are made on the detected edges. The held code is decoded into the controls an attenuator chain needs:
- a count of 6 dB coarse steps,
- a count of 1 dB fine steps,
- a mute flag for codes that have no defined gain.

A per-channel enable controls power to the analog path. Turning a channel off keeps its code, so the same setting comes back when the channel is turned on again.

Top module: `dual_gain_serial_ctl`

## Requirements
- R1: After reset every channel holds code 0. `mute` reads 1, `coarse_step` and `fine_step` read 0, `ser_dout` reads 0 and `path_on` follows `chan_en`.
- R2: A frame is the run of bits between a fall and the next rise of `ser_latch_n`. Data bits are sampled on rising edges of `ser_clk`. Bit 0 = 1 marks a store. Bit 1 is ignored. Bits 2..7 carry code bits 0..5. When the strobe rises after such an 8-bit store frame, the held code becomes the new code.
- R3: A store frame with any bit count other than eight leaves the held code unchanged.
- R4: Clock edges and data changes while `ser_latch_n` is high change neither the held code nor `ser_dout`.
- R5: A frame whose bit 0 is 0 is a readback. After the falling clock edge that ends bit k (k = 1..6), `ser_dout` carries held-code bit k-1. The readback does not change the held code.
- R6: `ser_dout` is 0 outside readback frames, during the first two bits of a readback, and after its sixth code bit.
- R7: For codes 1..42 (gain = code − 10 dB), with a = 42 − code: `coarse_step` = a / 6, `fine_step` = a mod 6 (0..5), and `mute` = 0.
- R8: Codes 0 and 43..63 give `mute` = 1, with `coarse_step` = 0 and `fine_step` = 0.
- R9: `path_on` follows `chan_en`. Turning a channel off and back on keeps its held code and decode outputs.
- R10: Each channel's port and register act independently of the other channel's pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | NCH | Serial clock, one per channel |
| ser_latch_n | input | NCH | Active-low frame strobe, one per channel |
| ser_din | input | NCH | Serial data in, one per channel |
| ser_dout | output | NCH | Serial readback data, one per channel |
| chan_en | input | NCH | Channel power enable |
| path_on | output | NCH | Power control for each analog path |
| mute | output | NCH | Output mute for undefined codes |
| coarse_step | output | NCH*3 | 6 dB attenuation steps per channel (3 bits each by default) |
| fine_step | output | NCH*3 | 1 dB vernier steps per channel (3 bits each by default) |

## Verification
The bench sends frames of seven and nine bits that carry the store flag.
- A design that commits on the bit count alone, or that lets the count wrap, would apply a bad code.

It also toggles the serial clock while the strobe is high.
- A design that does not gate on the strobe would shift in garbage, or would drive the output pin outside a frame.

The readback captures each output bit just before the next rising edge.
- This catches an off-by-one bit alignment.
- It also catches a reversed bit order, which would return the code with its bits reversed.

The decode is checked at codes 0, 1, 36, 42, 43 and 63 and at random codes.
- A wrong mute range or a wrong division by six shows up directly on the step outputs.

// File: rtl/gain_ctl_pkg.sv
package gain_ctl_pkg;

    // Width of a coarse step count able to hold the largest attenuation / step
    function automatic int coarse_bits(input int max_code, input int coarse_db);
        int top_steps;
        top_steps = (max_code - 1) / coarse_db;
        return (top_steps < 1) ? 1 : $clog2(top_steps + 1);
    endfunction

    // Width of a fine step count (0 .. coarse_db-1)
    function automatic int fine_bits(input int coarse_db);
        return (coarse_db < 2) ? 1 : $clog2(coarse_db);
    endfunction

endpackage

// File: rtl/gain_sync.sv
module gain_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gain_ser_slave.sv
module gain_ser_slave #(
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              latch_s,
    input  logic              sdi_s,
    output logic [GAIN_W-1:0] gain_o,
    output logic              sdo_o
);

    localparam int FRAME_BITS = GAIN_W + 2;
    localparam int OVER_CNT   = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(OVER_CNT + 1);

    typedef struct packed {
        logic              sclk_prev;
        logic              latch_prev;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [GAIN_W-1:0] shreg;
        logic [GAIN_W-1:0] gain;
        logic              sdo;
    } ser_state_t;

    ser_state_t q, d;

    logic rise, fall, active, start, stop;

    always_comb begin
        rise   = sclk_s & ~q.sclk_prev;
        fall   = ~sclk_s & q.sclk_prev;
        active = ~latch_s;
        start  = ~latch_s & q.latch_prev;
        stop   = latch_s & ~q.latch_prev;

        d            = q;
        d.sclk_prev  = sclk_s;
        d.latch_prev = latch_s;

        if (start) begin
            d.cnt   = '0;
            d.wr    = 1'b0;
            d.shreg = '0;
        end else if (active && rise) begin
            if (q.cnt == '0) begin
                d.wr = sdi_s;
            end
            for (int b = 0; b < GAIN_W; b++) begin
                if (q.cnt == CNT_W'(b + 2)) begin
                    d.shreg[b] = sdi_s;
                end
            end
            if (q.cnt < CNT_W'(OVER_CNT)) begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (!active) begin
            d.sdo = 1'b0;
        end else if (fall) begin
            d.sdo = 1'b0;
            for (int b = 0; b < GAIN_W; b++) begin
                if (q.cnt == CNT_W'(b + 2)) begin
                    d.sdo = q.gain[b] & ~q.wr;
                end
            end
        end

        if (stop && q.wr && (q.cnt == CNT_W'(FRAME_BITS))) begin
            d.gain = q.shreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.latch_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign gain_o = q.gain;
    assign sdo_o  = q.sdo;

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(OVER_CNT)); // R3

    AST_GAIN_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |=> $stable(q.gain)); // R3

    AST_READ_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !q.wr) |=> $stable(q.gain)); // R5

    AST_DOUT_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        q.sdo |-> (!q.wr && !q.latch_prev)); // R6

    AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_s && q.latch_prev) |=> !q.sdo); // R4

endmodule

// File: rtl/gain_decode.sv
module gain_decode #(
    parameter int GAIN_W    = 6,
    parameter int MAX_CODE  = 42,
    parameter int COARSE_DB = 6,
    parameter int COARSE_W  = 3,
    parameter int FINE_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GAIN_W-1:0]   code_i,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [FINE_W-1:0]   fine_o,
    output logic                mute_o
);

    localparam int ATT_W = GAIN_W + 1;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic                mute;
    } dec_state_t;

    dec_state_t q, d;

    logic [ATT_W-1:0] att;
    logic             out_of_range;

    always_comb begin
        att          = ATT_W'(MAX_CODE) - {1'b0, code_i};
        out_of_range = (code_i == '0) || ({1'b0, code_i} > ATT_W'(MAX_CODE));

        d = q;
        if (out_of_range) begin
            d.mute   = 1'b1;
            d.coarse = '0;
            d.fine   = '0;
        end else begin
            d.mute   = 1'b0;
            d.coarse = COARSE_W'(att / ATT_W'(COARSE_DB));
            d.fine   = FINE_W'(att % ATT_W'(COARSE_DB));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mute <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign coarse_o = q.coarse;
    assign fine_o   = q.fine;
    assign mute_o   = q.mute;

    AST_FINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.fine < FINE_W'(COARSE_DB)); // R7

    AST_MUTE_ZERO_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        q.mute |-> (q.coarse == '0 && q.fine == '0)); // R8

    AST_MUTE_FOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == '0) |=> q.mute); // R8

endmodule

// File: rtl/gain_chan.sv
module gain_chan
    import gain_ctl_pkg::*;
#(
    parameter int GAIN_W      = 6,
    parameter int MAX_CODE    = 42,
    parameter int COARSE_DB   = 6,
    parameter int SYNC_STAGES = 2,
    parameter int COARSE_W    = coarse_bits(MAX_CODE, COARSE_DB),
    parameter int FINE_W      = fine_bits(COARSE_DB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                latch_n_i,
    input  logic                sdi_i,
    input  logic                en_i,
    output logic                sdo_o,
    output logic                path_on_o,
    output logic                mute_o,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [FINE_W-1:0]   fine_o
);

    logic              sclk_s, latch_s, sdi_s;
    logic [GAIN_W-1:0] gain;
    logic              path_d, path_q;

    gain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .din(sclk_i), .dout(sclk_s));

    gain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_latch (
        .clk(clk), .rst_n(rst_n), .din(latch_n_i), .dout(latch_s));

    gain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .din(sdi_i), .dout(sdi_s));

    gain_ser_slave #(.GAIN_W(GAIN_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .latch_s (latch_s),
        .sdi_s   (sdi_s),
        .gain_o  (gain),
        .sdo_o   (sdo_o)
    );

    gain_decode #(
        .GAIN_W    (GAIN_W),
        .MAX_CODE  (MAX_CODE),
        .COARSE_DB (COARSE_DB),
        .COARSE_W  (COARSE_W),
        .FINE_W    (FINE_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_i   (gain),
        .coarse_o (coarse_o),
        .fine_o   (fine_o),
        .mute_o   (mute_o)
    );

    always_comb begin
        path_d = en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q <= 1'b0;
        end else begin
            path_q <= path_d;
        end
    end

    assign path_on_o = path_q;

    AST_EN_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_s && $changed(en_i)) |=> $stable(gain)); // R9

endmodule

// File: rtl/dual_gain_serial_ctl.sv
module dual_gain_serial_ctl
    import gain_ctl_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int GAIN_W      = 6,
    parameter int MAX_CODE    = 42,
    parameter int COARSE_DB   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic [NCH-1:0]                                      ser_clk,
    input  logic [NCH-1:0]                                      ser_latch_n,
    input  logic [NCH-1:0]                                      ser_din,
    output logic [NCH-1:0]                                      ser_dout,
    input  logic [NCH-1:0]                                      chan_en,
    output logic [NCH-1:0]                                      path_on,
    output logic [NCH-1:0]                                      mute,
    output logic [NCH*coarse_bits(MAX_CODE, COARSE_DB)-1:0]     coarse_step,
    output logic [NCH*fine_bits(COARSE_DB)-1:0]                 fine_step
);

    localparam int COARSE_W = coarse_bits(MAX_CODE, COARSE_DB);
    localparam int FINE_W   = fine_bits(COARSE_DB);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        gain_chan #(
            .GAIN_W      (GAIN_W),
            .MAX_CODE    (MAX_CODE),
            .COARSE_DB   (COARSE_DB),
            .SYNC_STAGES (SYNC_STAGES),
            .COARSE_W    (COARSE_W),
            .FINE_W      (FINE_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sclk_i    (ser_clk[c]),
            .latch_n_i (ser_latch_n[c]),
            .sdi_i     (ser_din[c]),
            .en_i      (chan_en[c]),
            .sdo_o     (ser_dout[c]),
            .path_on_o (path_on[c]),
            .mute_o    (mute[c]),
            .coarse_o  (coarse_step[c*COARSE_W +: COARSE_W]),
            .fine_o    (fine_step[c*FINE_W +: FINE_W])
        );
    end

endmodule

// File: tb/dual_gain_serial_ctl_test.sv
module dual_gain_serial_ctl_test;

    localparam int P = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sclk = 2'b00;
    logic [1:0] latch_n = 2'b11;
    logic [1:0] sdi = 2'b00;
    logic [1:0] en = 2'b00;
    logic [1:0] dout, path_on, mute;
    logic [5:0] coarse, fine;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int model [2];

    always #5 clk = ~clk;

    dual_gain_serial_ctl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (sclk),
        .ser_latch_n (latch_n),
        .ser_din     (sdi),
        .ser_dout    (dout),
        .chan_en     (en),
        .path_on     (path_on),
        .mute        (mute),
        .coarse_step (coarse),
        .fine_step   (fine)
    );

    function automatic int exp_mute(input int code);
        return (code == 0 || code > 42) ? 1 : 0;
    endfunction

    function automatic int exp_coarse(input int code);
        return exp_mute(code) ? 0 : (42 - code) / 6;
    endfunction

    function automatic int exp_fine(input int code);
        return exp_mute(code) ? 0 : (42 - code) % 6;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int ch, input int nbits, input logic [15:0] bits,
                         output logic [15:0] seen);
        seen = '0;
        latch_n[ch] = 1'b0;
        wait_n(P);
        for (int i = 0; i < nbits; i++) begin
            sdi[ch] = bits[i];
            wait_n(P);
            seen[i] = dout[ch];
            sclk[ch] = 1'b1;
            wait_n(P);
            sclk[ch] = 1'b0;
        end
        wait_n(P);
        seen[15] = dout[ch];
        latch_n[ch] = 1'b1;
        wait_n(10);
    endtask

    task automatic check_dec(input int ch, input string req);
        int c;
        c = model[ch];
        chk(int'(coarse[ch*3 +: 3]) == exp_coarse(c), req, int'(coarse[ch*3 +: 3]), exp_coarse(c));
        chk(int'(fine[ch*3 +: 3]) == exp_fine(c), req, int'(fine[ch*3 +: 3]), exp_fine(c));
        chk(int'(mute[ch]) == exp_mute(c), req, int'(mute[ch]), exp_mute(c));
    endtask

    task automatic do_write(input int ch, input int code, input int nbits, input string req);
        logic [15:0] bits, seen;
        bits = 16'($urandom);
        bits[0] = 1'b1;
        bits[7:2] = 6'(code);
        frame(ch, nbits, bits, seen);
        if (nbits == 8) model[ch] = code;
        chk(seen == 16'h0, "R6 dout during store", int'(seen), 0);
        chk(dout[ch] == 1'b0, "R6 dout after frame", int'(dout[ch]), 0);
        check_dec(ch, req);
    endtask

    task automatic do_read(input int ch);
        logic [15:0] bits, seen;
        bits = 16'($urandom);
        bits[0] = 1'b0;
        frame(ch, 8, bits, seen);
        chk(int'(seen[7:2]) == model[ch], "R5 readback", int'(seen[7:2]), model[ch]);
        chk(seen[1:0] == 2'b00 && seen[15] == 1'b0, "R6 dout outside code bits",
            int'({seen[15], seen[1:0]}), 0);
        check_dec(ch, "R5 read keeps code");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model[0] = 0;
        model[1] = 0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
        // R1 reset state
        chk(mute == 2'b11, "R1 mute", int'(mute), 3);
        chk(coarse == 6'd0 && fine == 6'd0, "R1 steps", int'({coarse, fine}), 0);
        chk(dout == 2'b00, "R1 dout", int'(dout), 0);
        chk(path_on == 2'b00, "R1 path_on", int'(path_on), 0);
        do_read(0);
        en = 2'b11;
        wait_n(4);
        chk(path_on == 2'b11, "R9 path on", int'(path_on), 3);

        // R2 R7 R8 directed codes
        do_write(0, 42, 8, "R7 code 42");
        do_read(0);
        do_write(0, 1, 8, "R7 code 1");
        do_read(0);
        do_write(0, 36, 8, "R7 code 36");
        do_write(0, 43, 8, "R8 code 43");
        do_read(0);
        do_write(0, 63, 8, "R8 code 63");
        do_write(0, 0, 8, "R8 code 0");
        do_write(0, 21, 8, "R2 store");
        do_read(0);

        // R3 bad lengths
        do_write(0, 5, 7, "R3 short frame");
        do_read(0);
        do_write(0, 9, 9, "R3 long frame");
        do_read(0);

        // R4 clocks while strobe high
        for (int i = 0; i < 10; i++) begin
            sdi[0] = 1'($urandom);
            wait_n(P);
            sclk[0] = 1'b1;
            chk(dout[0] == 1'b0, "R4 dout idle", int'(dout[0]), 0);
            wait_n(P);
            sclk[0] = 1'b0;
        end
        wait_n(10);
        check_dec(0, "R4 ignored clocks");
        do_read(0);

        // R10 independence
        do_write(1, 30, 8, "R10 ch1 store");
        check_dec(0, "R10 ch0 unaffected");
        do_read(0);
        do_write(0, 12, 8, "R10 ch0 store");
        check_dec(1, "R10 ch1 unaffected");
        do_read(1);

        // R9 enable keeps code
        en[0] = 1'b0;
        wait_n(4);
        chk(path_on == 2'b10, "R9 path off", int'(path_on), 2);
        check_dec(0, "R9 disabled keeps decode");
        do_read(0);
        en[0] = 1'b1;
        wait_n(4);
        chk(path_on == 2'b11, "R9 path back", int'(path_on), 3);
        check_dec(0, "R9 re-enable keeps decode");

        // random mix
        for (int it = 0; it < 120; it++) begin
            int ch, kind, nb;
            ch = int'($urandom % 2);
            kind = int'($urandom % 4);
            if (kind < 2) begin
                do_write(ch, int'($urandom % 64), 8, "R2 R7 R8 random store");
            end else if (kind == 2) begin
                do_read(ch);
            end else begin
                nb = (($urandom % 2) == 0) ? 7 : 9;
                if (($urandom % 3) == 0) nb = 3 + int'($urandom % 3);
                do_write(ch, int'($urandom % 64), nb, "R3 random bad length");
            end
            check_dec(1 - ch, "R10 other channel");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule